// File: doc/BRIEF.md
# Two-Port Total-Store-Order Memory Subsystem

This block gives two processor ports a shared 16-word memory with total store ordering. Each port issues one operation at a time over a valid/ready handshake: load, store, full fence, load fence, store fence, lock acquire or lock release. A store never writes the shared RAM directly. It is appended to a private FIFO write buffer for that port. A load first searches the issuing port's own buffer for the most recent pending store to the same full 32-bit address. If none is found, it reads the RAM word selected by the low address bits.

A drain engine retires buffered stores to the RAM oldest-first, one RAM write per cycle. When both ports have a store ready, it alternates between them round-robin. A store becomes ready to drain once it has been at the head of its buffer for `HOLD` cycles. A full fence waits until its own buffer has drained. A single global lock lets one port run a locked sequence. While the lock is held, the other port can neither load nor drain.

Two state machines are involved. The port controller has `PS_IDLE` (accept when ready) → `PS_RESP` (done pulse, always one cycle) → `PS_IDLE`. The lock tracker has `LK_FREE` → `LK_HELD0` or `LK_HELD1` on an accepted acquire, and back to `LK_FREE` on an accepted release by the holder.

Top module: `tso_mem_subsys`

## Requirements
- R1: After reset both buffers are empty, the lock is free, every RAM word reads 0, `done` is low and an idle port shows ready for a load.
- R2: Opcode 1 (store) is accepted whenever the port's buffer is not full. It appends the (address, data) pair as the newest entry and leaves the RAM unchanged for at least `HOLD` cycles, so the other port's load of that word still returns the old value.
- R3: Opcode 0 (load) returns the data of the newest pending store in the issuing port's own buffer whose full 32-bit address matches. An address that differs only above bit 3 does not match.
- R4: A load with no matching entry in its own buffer returns the RAM word at address bits [3:0]. The other port's pending stores are not visible.
- R5: Buffered stores reach the RAM oldest-first with at most one RAM write per cycle, so the newest of several stores to one word is the value left in RAM.
- R6: Opcode 2 (full fence) is accepted only when the issuing port's buffer is empty. After it completes, all earlier stores of that port are visible to the other port.
- R7: Opcodes 3 and 4 (load fence, store fence) are accepted at once and leave the buffer untouched.
- R8: Opcode 5 (lock) is accepted only when the lock is free and the requester's buffer is empty. Port 0 wins a same-cycle request. Opcode 6 (unlock) is accepted only from the holder with an empty buffer.
- R9: While one port holds the lock, the other port's loads are not accepted and its buffer does not drain.
- R10: A store to a full buffer (`DEPTH` entries) is held off with ready low until a drain frees an entry. Occupancy never exceeds `DEPTH`.
- R11: Every accepted operation raises `done` for exactly one cycle, on the cycle after acceptance. For loads, `rdata` carries the value in that cycle. Opcode 7 is never accepted.
- R12: With a store followed by a load on each port to crossed addresses, both loads can return 0. With a full fence between each store and load, at least one load returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req_valid | input | 1 | Port 0 request valid |
| p0_req_ready | output | 1 | Port 0 request ready (depends on opcode and state) |
| p0_req_op | input | 3 | Port 0 opcode |
| p0_req_addr | input | 32 | Port 0 address |
| p0_req_wdata | input | 32 | Port 0 store data |
| p0_rsp_done | output | 1 | Port 0 completion pulse |
| p0_rsp_rdata | output | 32 | Port 0 load result |
| p1_req_valid | input | 1 | Port 1 request valid |
| p1_req_ready | output | 1 | Port 1 request ready |
| p1_req_op | input | 3 | Port 1 opcode |
| p1_req_addr | input | 32 | Port 1 address |
| p1_req_wdata | input | 32 | Port 1 store data |
| p1_rsp_done | output | 1 | Port 1 completion pulse |
| p1_rsp_rdata | output | 32 | Port 1 load result |

## Verification
The bench builds the block with its defaults: `DEPTH` 4, `HOLD` 12 and 16 RAM words. A hold of 12 cycles exceeds the 7 cycles a port needs to issue four stores. This lets the bench fill a buffer and see the stall, and lets both store-buffering loads complete before either store drains. Sixteen words give room for fresh addresses in each scenario and for an alias address (0x103 against 0x3) that tests full-address matching. The lock scenario keeps the other port blocked for 20 cycles, longer than `HOLD`, so a drain that ignored the lock would show up in the holder's load.

// File: rtl/tso_pkg.sv
package tso_pkg;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_MFENCE = 3'd2,
        OP_LFENCE = 3'd3,
        OP_SFENCE = 3'd4,
        OP_LOCK   = 3'd5,
        OP_UNLOCK = 3'd6
    } op_e;

    typedef enum logic {
        PS_IDLE,
        PS_RESP
    } port_state_e;

    typedef enum logic [1:0] {
        LK_FREE,
        LK_HELD0,
        LK_HELD1
    } lock_state_e;

endpackage

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int IW    = 4,
    parameter int DW    = 32,
    parameter int HOLD  = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [AW-1:0]                push_addr,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    input  logic [AW-1:0]                look_addr,
    output logic                         full,
    output logic                         empty,
    output logic [IW-1:0]                head_idx,
    output logic [DW-1:0]                head_data,
    output logic                         head_ripe,
    output logic                         look_hit,
    output logic [DW-1:0]                look_data,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int AGW = $clog2(HOLD + 1);

    logic [AW-1:0]  addr_q [DEPTH];
    logic [DW-1:0]  data_q [DEPTH];
    logic [PW-1:0]  wr_ptr_q;
    logic [PW-1:0]  rd_ptr_q;
    logic [CW-1:0]  cnt_q;
    logic [AGW-1:0] age_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] ptr);
        if (ptr == PW'(DEPTH - 1)) begin
            return '0;
        end
        return ptr + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            age_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= bump(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
            // the head entry ages while it waits; a new head starts again at zero
            if (pop || (cnt_q == '0)) begin
                age_q <= '0;
            end else if (age_q != AGW'(HOLD)) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    // oldest to newest, the last match wins: newest-entry forwarding
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int s;
            s = int'(rd_ptr_q) + k;
            if (s >= DEPTH) begin
                s = s - DEPTH;
            end
            if ((k < int'(cnt_q)) && (addr_q[PW'(s)] == look_addr)) begin
                look_hit  = 1'b1;
                look_data = data_q[PW'(s)];
            end
        end
    end

    logic [AW-1:0] head_addr;
    assign head_addr = addr_q[rd_ptr_q];
    assign head_idx  = head_addr[IW-1:0];
    assign head_data = data_q[rd_ptr_q];
    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign head_ripe = !empty && (age_q == AGW'(HOLD));
    assign count     = cnt_q;

endmodule

// File: rtl/tso_drain_arb.sv
module tso_drain_arb #(
    parameter int NPORT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] eligible,
    output logic [NPORT-1:0] grant
);

    localparam int PIW = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic [PIW-1:0] last_q;
    logic [PIW-1:0] win_idx;

    // search starts just after the last winner, so ports alternate
    always_comb begin
        logic found;
        found   = 1'b0;
        grant   = '0;
        win_idx = last_q;
        for (int off = 1; off <= NPORT; off++) begin
            int c;
            c = int'(last_q) + off;
            if (c >= NPORT) begin
                c = c - NPORT;
            end
            if (!found && eligible[PIW'(c)]) begin
                found            = 1'b1;
                grant[PIW'(c)]   = 1'b1;
                win_idx          = PIW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= PIW'(NPORT - 1);
        end else if (|grant) begin
            last_q <= win_idx;
        end
    end

endmodule

// File: rtl/tso_port_ctrl.sv
module tso_port_ctrl
    import tso_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic          buf_full,
    input  logic          buf_empty,
    input  logic          fwd_hit,
    input  logic [DW-1:0] fwd_data,
    input  logic [DW-1:0] mem_rdata,
    input  logic          blocked,
    input  logic          lock_avail,
    input  logic          lock_mine,
    output logic          req_ready,
    output logic          accept,
    output logic          buf_push,
    output logic          take_lock,
    output logic          drop_lock,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata
);

    port_state_e state_q;
    port_state_e state_d;
    logic [DW-1:0] rdata_q;
    op_e op;

    assign op = op_e'(req_op);

    // acceptance rule per opcode, only while idle
    always_comb begin
        req_ready = 1'b0;
        if (state_q == PS_IDLE) begin
            unique case (op)
                OP_LOAD:   req_ready = !blocked;
                OP_STORE:  req_ready = !buf_full;
                OP_MFENCE: req_ready = buf_empty;
                OP_LFENCE: req_ready = 1'b1;
                OP_SFENCE: req_ready = 1'b1;
                OP_LOCK:   req_ready = lock_avail && buf_empty;
                OP_UNLOCK: req_ready = lock_mine && buf_empty;
                default:   req_ready = 1'b0;
            endcase
        end
    end

    assign accept    = req_valid && req_ready;
    assign buf_push  = accept && (op == OP_STORE);
    assign take_lock = accept && (op == OP_LOCK);
    assign drop_lock = accept && (op == OP_UNLOCK);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (accept) state_d = PS_RESP;
            PS_RESP: state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                if (op == OP_LOAD) begin
                    rdata_q <= fwd_hit ? fwd_data : mem_rdata;
                end else begin
                    rdata_q <= '0;
                end
            end
        end
    end

    always_comb begin
        rsp_done  = (state_q == PS_RESP);
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/tso_mem_subsys.sv
module tso_mem_subsys
    import tso_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int RAM_WORDS = 16,
    parameter int HOLD      = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p0_req_valid,
    output logic          p0_req_ready,
    input  logic [2:0]    p0_req_op,
    input  logic [AW-1:0] p0_req_addr,
    input  logic [DW-1:0] p0_req_wdata,
    output logic          p0_rsp_done,
    output logic [DW-1:0] p0_rsp_rdata,
    input  logic          p1_req_valid,
    output logic          p1_req_ready,
    input  logic [2:0]    p1_req_op,
    input  logic [AW-1:0] p1_req_addr,
    input  logic [DW-1:0] p1_req_wdata,
    output logic          p1_rsp_done,
    output logic [DW-1:0] p1_rsp_rdata
);

    localparam int NPORT = 2;
    localparam int IW    = $clog2(RAM_WORDS);
    localparam int CW    = $clog2(DEPTH + 1);

    logic [NPORT-1:0] req_valid;
    logic [2:0]       req_op    [NPORT];
    logic [AW-1:0]    req_addr  [NPORT];
    logic [DW-1:0]    req_wdata [NPORT];

    logic [NPORT-1:0] ready_v, accept, buf_push, take_lock, drop_lock, done_v;
    logic [NPORT-1:0] buf_full, buf_empty, head_ripe, fwd_hit;
    logic [NPORT-1:0] blocked, lock_mine, lock_avail, eligible, grant;
    logic [DW-1:0]    rdata_v   [NPORT];
    logic [DW-1:0]    fwd_data  [NPORT];
    logic [DW-1:0]    mem_rdata [NPORT];
    logic [IW-1:0]    head_idx  [NPORT];
    logic [DW-1:0]    head_data [NPORT];
    logic [CW-1:0]    buf_count [NPORT];

    logic [DW-1:0] ram_q [RAM_WORDS];
    lock_state_e   lk_q;
    lock_state_e   lk_d;
    logic          p0_lock_req;

    assign req_valid[0] = p0_req_valid;
    assign req_valid[1] = p1_req_valid;
    assign req_op[0]    = p0_req_op;
    assign req_op[1]    = p1_req_op;
    assign req_addr[0]  = p0_req_addr;
    assign req_addr[1]  = p1_req_addr;
    assign req_wdata[0] = p0_req_wdata;
    assign req_wdata[1] = p1_req_wdata;

    assign p0_req_ready = ready_v[0];
    assign p1_req_ready = ready_v[1];
    assign p0_rsp_done  = done_v[0];
    assign p1_rsp_done  = done_v[1];
    assign p0_rsp_rdata = rdata_v[0];
    assign p1_rsp_rdata = rdata_v[1];

    // lock ownership view per port; port 0 wins a same-cycle acquire
    assign p0_lock_req = req_valid[0] && (req_op[0] == OP_LOCK);

    always_comb begin
        blocked[0]    = (lk_q == LK_HELD1);
        blocked[1]    = (lk_q == LK_HELD0);
        lock_mine[0]  = (lk_q == LK_HELD0);
        lock_mine[1]  = (lk_q == LK_HELD1);
        lock_avail[0] = (lk_q == LK_FREE);
        lock_avail[1] = (lk_q == LK_FREE) && !p0_lock_req;
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            tso_store_buffer #(
                .DEPTH (DEPTH),
                .AW    (AW),
                .IW    (IW),
                .DW    (DW),
                .HOLD  (HOLD)
            ) u_buf (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (buf_push[p]),
                .push_addr (req_addr[p]),
                .push_data (req_wdata[p]),
                .pop       (grant[p]),
                .look_addr (req_addr[p]),
                .full      (buf_full[p]),
                .empty     (buf_empty[p]),
                .head_idx  (head_idx[p]),
                .head_data (head_data[p]),
                .head_ripe (head_ripe[p]),
                .look_hit  (fwd_hit[p]),
                .look_data (fwd_data[p]),
                .count     (buf_count[p])
            );

            assign mem_rdata[p] = ram_q[req_addr[p][IW-1:0]];
            assign eligible[p]  = head_ripe[p] && !blocked[p];

            tso_port_ctrl #(
                .DW (DW)
            ) u_ctrl (
                .clk        (clk),
                .rst_n      (rst_n),
                .req_valid  (req_valid[p]),
                .req_op     (req_op[p]),
                .buf_full   (buf_full[p]),
                .buf_empty  (buf_empty[p]),
                .fwd_hit    (fwd_hit[p]),
                .fwd_data   (fwd_data[p]),
                .mem_rdata  (mem_rdata[p]),
                .blocked    (blocked[p]),
                .lock_avail (lock_avail[p]),
                .lock_mine  (lock_mine[p]),
                .req_ready  (ready_v[p]),
                .accept     (accept[p]),
                .buf_push   (buf_push[p]),
                .take_lock  (take_lock[p]),
                .drop_lock  (drop_lock[p]),
                .rsp_done   (done_v[p]),
                .rsp_rdata  (rdata_v[p])
            );
        end
    endgenerate

    tso_drain_arb #(
        .NPORT (NPORT)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .eligible (eligible),
        .grant    (grant)
    );

    // shared RAM: one drained store per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < RAM_WORDS; w++) begin
                ram_q[w] <= '0;
            end
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (grant[p]) begin
                    ram_q[head_idx[p]] <= head_data[p];
                end
            end
        end
    end

    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_FREE: begin
                if (take_lock[0]) begin
                    lk_d = LK_HELD0;
                end else if (take_lock[1]) begin
                    lk_d = LK_HELD1;
                end
            end
            LK_HELD0: if (drop_lock[0]) lk_d = LK_FREE;
            LK_HELD1: if (drop_lock[1]) lk_d = LK_FREE;
            default:  lk_d = LK_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= LK_FREE;
        end else begin
            lk_q <= lk_d;
        end
    end

endmodule

// File: rtl/tso_mem_checker.sv
module tso_mem_checker
    import tso_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 accept,
    input logic [1:0]                 grant,
    input logic [1:0]                 blocked,
    input logic [1:0]                 done,
    input logic [2:0]                 op0,
    input logic [2:0]                 op1,
    input logic [$clog2(DEPTH+1)-1:0] cnt0,
    input logic [$clog2(DEPTH+1)-1:0] cnt1
);

    localparam int CW = $clog2(DEPTH + 1);

    AST_DONE_FOLLOWS_P0: assert property (@(posedge clk) disable iff (!rst_n)
        accept[0] |=> done[0]); // R11
    AST_DONE_FOLLOWS_P1: assert property (@(posedge clk) disable iff (!rst_n)
        accept[1] |=> done[1]); // R11
    AST_DONE_CAUSED_P0: assert property (@(posedge clk) disable iff (!rst_n)
        done[0] |-> $past(accept[0])); // R11
    AST_DONE_CAUSED_P1: assert property (@(posedge clk) disable iff (!rst_n)
        done[1] |-> $past(accept[1])); // R11
    AST_STORE_GROWS_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (accept[0] && op0 == OP_STORE && !grant[0]) |=> (cnt0 == $past(cnt0) + 1'b1)); // R2
    AST_ONE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R5
    AST_MFENCE_EMPTY_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (accept[0] && op0 == OP_MFENCE) |-> (cnt0 == '0)); // R6
    AST_MFENCE_EMPTY_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept[1] && op1 == OP_MFENCE) |-> (cnt1 == '0)); // R6
    AST_LOCKOP_EMPTY_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (accept[0] && (op0 == OP_LOCK || op0 == OP_UNLOCK)) |-> (cnt0 == '0)); // R8
    AST_LOCKOP_EMPTY_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept[1] && (op1 == OP_LOCK || op1 == OP_UNLOCK)) |-> (cnt1 == '0)); // R8
    AST_LOAD_UNBLOCKED_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (accept[0] && op0 == OP_LOAD) |-> !blocked[0]); // R9
    AST_LOAD_UNBLOCKED_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept[1] && op1 == OP_LOAD) |-> !blocked[1]); // R9
    AST_DRAIN_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & blocked) == 2'b00); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0 <= CW'(DEPTH)) && (cnt1 <= CW'(DEPTH))); // R10

endmodule

bind tso_mem_subsys tso_mem_checker #(
    .DEPTH (DEPTH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .grant   (grant),
    .blocked (blocked),
    .done    (done_v),
    .op0     (req_op[0]),
    .op1     (req_op[1]),
    .cnt0    (buf_count[0]),
    .cnt1    (buf_count[1])
);

// File: tb/tb_tso_mem_subsys.sv
module tb_tso_mem_subsys;
    import tso_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld  [2];
    logic [2:0]  op   [2];
    logic [31:0] addr [2];
    logic [31:0] wd   [2];
    logic        rdy  [2];
    logic        done [2];
    logic [31:0] rdat [2];

    int checks = 0;
    int fails  = 0;
    logic [31:0] last_rd [2];

    logic [31:0] exp0[$], exp1[$];
    bit          chk0[$], chk1[$];
    string       tag0[$], tag1[$];

    always #2 clk = ~clk;

    tso_mem_subsys dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .p0_req_valid (vld[0]),
        .p0_req_ready (rdy[0]),
        .p0_req_op    (op[0]),
        .p0_req_addr  (addr[0]),
        .p0_req_wdata (wd[0]),
        .p0_rsp_done  (done[0]),
        .p0_rsp_rdata (rdat[0]),
        .p1_req_valid (vld[1]),
        .p1_req_ready (rdy[1]),
        .p1_req_op    (op[1]),
        .p1_req_addr  (addr[1]),
        .p1_req_wdata (wd[1]),
        .p1_rsp_done  (done[1]),
        .p1_rsp_rdata (rdat[1])
    );

    function automatic void check(bit ok, string req, string what,
                                  logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endfunction

    // driver: present one operation, wait for acceptance, log expectation
    task automatic do_op(input int p, input logic [2:0] o, input logic [31:0] a,
                         input logic [31:0] d, input bit chk, input logic [31:0] e,
                         input string tag, output int waited);
        @(negedge clk);
        vld[p] = 1'b1; op[p] = o; addr[p] = a; wd[p] = d;
        waited = 0;
        #1;
        while (!rdy[p] && waited < 2000) begin
            @(negedge clk);
            #1;
            waited++;
        end
        if (p == 0) begin
            exp0.push_back(e); chk0.push_back(chk); tag0.push_back(tag);
        end else begin
            exp1.push_back(e); chk1.push_back(chk); tag1.push_back(tag);
        end
        @(posedge clk);
        @(negedge clk);
        vld[p] = 1'b0;
        check(done[p] == 1'b1, "R11", "done one cycle after accept", 32'(done[p]), 1);
    endtask

    // present an operation for n cycles and require it to stay refused
    task automatic refused(input int p, input logic [2:0] o, input logic [31:0] a,
                           input int n, input string tag);
        @(negedge clk);
        vld[p] = 1'b1; op[p] = o; addr[p] = a; wd[p] = 32'h0;
        for (int i = 0; i < n; i++) begin
            #1;
            check(rdy[p] == 1'b0, tag, "request must be held off", 32'(rdy[p]), 0);
            @(negedge clk);
        end
        vld[p] = 1'b0;
    endtask

    // monitor: scoreboard pop on every completion
    always @(negedge clk) begin
        logic [31:0] e;
        bit c;
        string t;
        if (rst_n) begin
            if (done[0]) begin
                if (exp0.size() == 0) begin
                    check(1'b0, "R11", "p0 done with nothing issued", 1, 0);
                end else begin
                    e = exp0.pop_front(); c = chk0.pop_front(); t = tag0.pop_front();
                    if (c) check(rdat[0] == e, t, "p0 load data", rdat[0], e);
                    last_rd[0] = rdat[0];
                end
            end
            if (done[1]) begin
                if (exp1.size() == 0) begin
                    check(1'b0, "R11", "p1 done with nothing issued", 1, 0);
                end else begin
                    e = exp1.pop_front(); c = chk1.pop_front(); t = tag1.pop_front();
                    if (c) check(rdat[1] == e, t, "p1 load data", rdat[1], e);
                    last_rd[1] = rdat[1];
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int w;
        for (int p = 0; p < 2; p++) begin
            vld[p] = 1'b0; op[p] = OP_LOAD; addr[p] = '0; wd[p] = '0; last_rd[p] = '0;
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle and empty after reset
        check(rdy[0] == 1'b1, "R1", "p0 ready for load", 32'(rdy[0]), 1);
        check(done[0] == 1'b0 && done[1] == 1'b0, "R1", "no done", 32'(done[0]), 0);
        do_op(0, OP_LOAD, 32'd5, 0, 1, 32'h0, "R1", w);

        // R2 / R4: pending store invisible to other port; R3 forwarding
        do_op(0, OP_STORE, 32'd1, 32'hA1, 0, 0, "R2", w);
        do_op(1, OP_LOAD, 32'd1, 0, 1, 32'h0, "R4", w);
        do_op(0, OP_LOAD, 32'd1, 0, 1, 32'hA1, "R3", w);
        do_op(0, OP_STORE, 32'd2, 32'h11, 0, 0, "R2", w);
        do_op(0, OP_STORE, 32'd2, 32'h22, 0, 0, "R2", w);
        do_op(0, OP_LOAD, 32'd2, 0, 1, 32'h22, "R3", w);
        do_op(1, OP_STORE, 32'd3, 32'h33, 0, 0, "R2", w);
        do_op(1, OP_LOAD, 32'h103, 0, 1, 32'h0, "R3", w);
        do_op(1, OP_LOAD, 32'd3, 0, 1, 32'h33, "R3", w);

        // R6 / R5: fence waits for drain, RAM keeps newest value
        do_op(0, OP_MFENCE, 0, 0, 0, 0, "R6", w);
        check(w > 0, "R6", "fence waited for non-empty buffer", 32'(w), 1);
        do_op(1, OP_LOAD, 32'd1, 0, 1, 32'hA1, "R6", w);
        do_op(1, OP_LOAD, 32'd2, 0, 1, 32'h22, "R5", w);

        // R7: light fences accepted immediately, no flush
        do_op(0, OP_STORE, 32'd4, 32'h44, 0, 0, "R7", w);
        do_op(0, OP_LFENCE, 0, 0, 0, 0, "R7", w);
        check(w == 0, "R7", "load fence without wait", 32'(w), 0);
        do_op(0, OP_SFENCE, 0, 0, 0, 0, "R7", w);
        check(w == 0, "R7", "store fence without wait", 32'(w), 0);
        do_op(1, OP_LOAD, 32'd4, 0, 1, 32'h0, "R7", w);

        // R10: full buffer stalls stores
        do_op(0, OP_MFENCE, 0, 0, 0, 0, "R6", w);
        for (int i = 0; i < 4; i++) begin
            do_op(0, OP_STORE, 32'(8 + i), 32'(32'h80 + i), 0, 0, "R10", w);
        end
        refused(0, OP_STORE, 32'd12, 3, "R10");
        do_op(0, OP_STORE, 32'd12, 32'hC0, 0, 0, "R10", w);
        check(w > 0, "R10", "store waited for free entry", 32'(w), 1);
        do_op(0, OP_MFENCE, 0, 0, 0, 0, "R6", w);
        do_op(1, OP_LOAD, 32'd8, 0, 1, 32'h80, "R5", w);
        do_op(1, OP_LOAD, 32'd12, 0, 1, 32'hC0, "R10", w);

        // R8 / R9: global lock
        do_op(1, OP_MFENCE, 0, 0, 0, 0, "R6", w);
        do_op(0, OP_STORE, 32'd5, 32'h55, 0, 0, "R8", w);
        refused(0, OP_LOCK, 0, 3, "R8");
        do_op(0, OP_LOCK, 0, 0, 0, 0, "R8", w);
        do_op(1, OP_STORE, 32'd6, 32'h66, 0, 0, "R9", w);
        refused(1, OP_UNLOCK, 0, 2, "R8");
        refused(1, OP_LOCK, 0, 2, "R8");
        refused(1, OP_LOAD, 32'd6, 20, "R9");
        do_op(0, OP_LOAD, 32'd6, 0, 1, 32'h0, "R9", w);
        do_op(0, OP_UNLOCK, 0, 0, 0, 0, "R8", w);
        do_op(1, OP_LOAD, 32'd6, 0, 1, 32'h66, "R9", w);
        do_op(1, OP_MFENCE, 0, 0, 0, 0, "R9", w);
        do_op(0, OP_LOAD, 32'd6, 0, 1, 32'h66, "R9", w);
        do_op(0, OP_LOAD, 32'd5, 0, 1, 32'h55, "R8", w);

        // R12: store buffering, plain then fenced
        fork
            begin
                int w0;
                do_op(0, OP_STORE, 32'd13, 32'h1, 0, 0, "R12", w0);
                do_op(0, OP_LOAD, 32'd14, 0, 1, 32'h0, "R12", w0);
            end
            begin
                int w1;
                do_op(1, OP_STORE, 32'd14, 32'h1, 0, 0, "R12", w1);
                do_op(1, OP_LOAD, 32'd13, 0, 1, 32'h0, "R12", w1);
            end
        join
        fork
            begin
                int w0;
                do_op(0, OP_STORE, 32'd15, 32'h1, 0, 0, "R12", w0);
                do_op(0, OP_MFENCE, 0, 0, 0, 0, "R12", w0);
                do_op(0, OP_LOAD, 32'd7, 0, 0, 0, "R12", w0);
            end
            begin
                int w1;
                do_op(1, OP_STORE, 32'd7, 32'h1, 0, 0, "R12", w1);
                do_op(1, OP_MFENCE, 0, 0, 0, 0, "R12", w1);
                do_op(1, OP_LOAD, 32'd15, 0, 0, 0, "R12", w1);
            end
        join
        @(negedge clk);
        check((last_rd[0] != 0) || (last_rd[1] != 0), "R12",
              "fenced loads not both zero", last_rd[0] | last_rd[1], 1);

        // R11: reserved opcode never accepted
        refused(0, 3'd7, 0, 2, "R11");

        repeat (3) @(negedge clk);
        check(exp0.size() == 0 && exp1.size() == 0, "R11", "all completions seen",
              32'(exp0.size() + exp1.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule